// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block holds the 14-bit instruction address of a small pipelined microcontroller core and chooses, once per instruction cycle, where execution goes next. The candidates are the interrupt vectors, a return address popped from an on-block hardware stack, a jump or call target, a new low byte written by software, a two-word skip, and plain sequential increment. The decoder, the interrupt arbiter and the program memory sit outside. The block receives one-cycle decoded strobes and operand fields, and it returns the address together with a discard flag for the fetch stage.

The counter only moves on the instruction-cycle strobe `cyc_en`, so one instruction cycle can span several system clocks. Jump and call targets take their top bit from a selectable bit of the bank-pointer input. A skip stays inside the current 8K-word bank. Any change of flow other than a plain increment raises `flush`, which marks the already-fetched word as dead and so makes that instruction take two cycles. The return stack is eight entries deep. It wraps on overflow, repeats its last value on underflow, and reports both conditions.

Top module: `prog_addr_seq`

## Requirements
- R1: While `rst_n` is low, `pc` is 0x0000 and `flush`, `stk_ovf` and `stk_udf` are 0; the return stack is emptied and a later underflow returns 0x0000.
- R2: On clock edges where `cyc_en` is 0, `pc`, `flush`, `stk_ovf` and `stk_udf` keep their values, whatever the control inputs are.
- R3: On a `cyc_en` edge with no control active, `pc` becomes `pc+1` modulo 2^14 and `flush` becomes 0.
- R4: When `irq_valid` is 1 and `irq_sel` is 0..5, `pc` becomes 4*(irq_sel+1), which gives 0x004, 0x008, 0x00C, 0x010, 0x014 or 0x018, and `pc+1` is pushed. When `irq_sel` is 6 or 7, the request is ignored and the lower sources decide.
- R5: A skip (`do_skip`) keeps bit 13 and sets bits 12..0 to (bits 12..0 + 2) mod 2^13.
- R6: A low-byte write (`wr_lo`) sets bits 7..0 to `lo_data` and keeps bits 13..8.
- R7: A jump (`do_jump`) or call (`do_call`) loads bits 12..0 from `jmp_addr` and bit 13 from `bank_ptr[5]`. A call also pushes `pc+1`.
- R8: A return (`do_ret`) loads all 14 bits from the top stack entry and pops it.
- R9: Priority, highest first: reset, valid interrupt, return, jump/call, low-byte write, skip, increment. Only the winning source acts on the stack.
- R10: After a `cyc_en` edge, `flush` is 1 if the chosen source was anything other than increment, and 0 otherwise.
- R11: The stack holds 8 entries. A push while full overwrites the oldest entry, and `stk_ovf` is 1 for that instruction cycle only.
- R12: A pop while empty returns the most recently popped value again (0x0000 if none since reset) and leaves the stack unchanged. `stk_udf` is 1 for that instruction cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-clock instruction-cycle strobe |
| irq_valid | input | 1 | Interrupt entry requested |
| irq_sel | input | 3 | Index of the interrupt source (0..5) |
| do_ret | input | 1 | Return from subroutine or interrupt |
| do_jump | input | 1 | Unconditional jump |
| do_call | input | 1 | Subroutine call |
| wr_lo | input | 1 | Write of the counter's low byte |
| lo_data | input | 8 | Byte written to the low byte |
| do_skip | input | 1 | Skip the next instruction |
| jmp_addr | input | 13 | Address field of the jump/call word |
| bank_ptr | input | 8 | Bank-pointer register value |
| pc | output | 14 | Current instruction address |
| flush | output | 1 | Discard the prefetched word |
| stk_ovf | output | 1 | Last push overwrote the oldest entry |
| stk_udf | output | 1 | Last pop found the stack empty |

## Verification
The assertions check, on every clock, the properties that involve one strobe in isolation. These are holding between strobes, plain increment, the bank-preserving skip, the low-byte merge, the bank-bit jump target, the vector alignment of an interrupt entry, the discard flag after a change of flow, and that the two stack flags never coincide. Other behaviours need history, so only the bench's scenarios can show them. These are the value popped on return, the overwrite of the oldest entry after nine nested calls, the replay of the last popped value on underflow, and the priority resolution when several strobes arrive together. The bench's reference model tracks all of this and is compared against the outputs on every clock.

// File: rtl/pas_pkg.sv
package pas_pkg;
    typedef enum logic [2:0] {
        SRC_INC  = 3'd0,
        SRC_SKIP = 3'd1,
        SRC_LOWR = 3'd2,
        SRC_JUMP = 3'd3,
        SRC_RET  = 3'd4,
        SRC_IRQ  = 3'd5
    } src_e;
endpackage

// File: rtl/pas_ret_stack.sv
module pas_ret_stack #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_data,
    output logic [PC_W-1:0] top_data,
    output logic            full,
    output logic            empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PC_W-1:0]  mem_q [DEPTH];
    logic [PTR_W-1:0] sp_d, sp_q, sp_next, sp_prev;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign sp_next = (sp_q == PTR_W'(DEPTH - 1)) ? '0 : sp_q + PTR_W'(1);
    assign sp_prev = (sp_q == '0) ? PTR_W'(DEPTH - 1) : sp_q - PTR_W'(1);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    // an empty pop replays the slot the last pop left behind
    assign top_data = empty ? mem_q[sp_q] : mem_q[sp_prev];

    always_comb begin
        sp_d  = sp_q;
        cnt_d = cnt_q;
        if (push) begin
            sp_d = sp_next;
            if (!full) cnt_d = cnt_q + CNT_W'(1);
        end else if (pop && !empty) begin
            sp_d  = sp_prev;
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            sp_q  <= sp_d;
            cnt_q <= cnt_d;
            if (push) mem_q[sp_q] <= push_data;
        end
    end
endmodule

// File: rtl/pas_next_addr.sv
module pas_next_addr
    import pas_pkg::*;
#(
    parameter int PC_W     = 14,
    parameter int LO_W     = 8,
    parameter int IRQ_W    = 3,
    parameter int N_IRQ    = 6,
    parameter int VEC_STEP = 4,
    parameter int BP_W     = 8,
    parameter int BANK_BIT = 5,
    parameter int SKIP_INC = 2
) (
    input  logic [PC_W-1:0]  pc,
    input  logic             irq_valid,
    input  logic [IRQ_W-1:0] irq_sel,
    input  logic             do_ret,
    input  logic             do_jump,
    input  logic             do_call,
    input  logic             wr_lo,
    input  logic [LO_W-1:0]  lo_data,
    input  logic             do_skip,
    input  logic [PC_W-2:0]  jmp_addr,
    input  logic [BP_W-1:0]  bank_ptr,
    input  logic [PC_W-1:0]  ret_addr,
    output logic [PC_W-1:0]  next_pc,
    output src_e             src,
    output logic             push,
    output logic             pop
);
    localparam int BNK = PC_W - 1;

    logic            irq_ok;
    logic [PC_W-1:0] vec;
    logic [BNK-1:0]  skip_lo;

    assign irq_ok  = irq_valid && (32'(irq_sel) < N_IRQ);
    assign vec     = PC_W'((32'(irq_sel) + 1) * VEC_STEP);
    assign skip_lo = pc[BNK-1:0] + BNK'(SKIP_INC);

    always_comb begin
        if (irq_ok) begin
            src = SRC_IRQ;  next_pc = vec;
        end else if (do_ret) begin
            src = SRC_RET;  next_pc = ret_addr;
        end else if (do_jump || do_call) begin
            src = SRC_JUMP; next_pc = {bank_ptr[BANK_BIT], jmp_addr};
        end else if (wr_lo) begin
            src = SRC_LOWR; next_pc = {pc[PC_W-1:LO_W], lo_data};
        end else if (do_skip) begin
            src = SRC_SKIP; next_pc = {pc[BNK], skip_lo};
        end else begin
            src = SRC_INC;  next_pc = pc + PC_W'(1);
        end
        push = (src == SRC_IRQ) || ((src == SRC_JUMP) && do_call);
        pop  = (src == SRC_RET);
    end
endmodule

// File: rtl/prog_addr_seq.sv
module prog_addr_seq
    import pas_pkg::*;
#(
    parameter int PC_W      = 14,
    parameter int LO_W      = 8,
    parameter int IRQ_W     = 3,
    parameter int N_IRQ     = 6,
    parameter int VEC_STEP  = 4,
    parameter int BP_W      = 8,
    parameter int BANK_BIT  = 5,
    parameter int STK_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             irq_valid,
    input  logic [IRQ_W-1:0] irq_sel,
    input  logic             do_ret,
    input  logic             do_jump,
    input  logic             do_call,
    input  logic             wr_lo,
    input  logic [LO_W-1:0]  lo_data,
    input  logic             do_skip,
    input  logic [PC_W-2:0]  jmp_addr,
    input  logic [BP_W-1:0]  bank_ptr,
    output logic [PC_W-1:0]  pc,
    output logic             flush,
    output logic             stk_ovf,
    output logic             stk_udf
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            flush;
        logic            ovf;
        logic            udf;
    } seq_st_t;

    seq_st_t         st_d, st_q;
    logic [PC_W-1:0] nxt_pc, ret_addr;
    src_e            src;
    logic            want_push, want_pop, stk_full, stk_empty;

    pas_next_addr #(
        .PC_W(PC_W), .LO_W(LO_W), .IRQ_W(IRQ_W), .N_IRQ(N_IRQ),
        .VEC_STEP(VEC_STEP), .BP_W(BP_W), .BANK_BIT(BANK_BIT), .SKIP_INC(2)
    ) u_sel (
        .pc(st_q.pc), .irq_valid(irq_valid), .irq_sel(irq_sel),
        .do_ret(do_ret), .do_jump(do_jump), .do_call(do_call),
        .wr_lo(wr_lo), .lo_data(lo_data), .do_skip(do_skip),
        .jmp_addr(jmp_addr), .bank_ptr(bank_ptr), .ret_addr(ret_addr),
        .next_pc(nxt_pc), .src(src), .push(want_push), .pop(want_pop)
    );

    pas_ret_stack #(.DEPTH(STK_DEPTH), .PC_W(PC_W)) u_stk (
        .clk(clk), .rst_n(rst_n),
        .push(cyc_en && want_push), .pop(cyc_en && want_pop),
        .push_data(st_q.pc + PC_W'(1)), .top_data(ret_addr),
        .full(stk_full), .empty(stk_empty)
    );

    always_comb begin
        st_d = st_q;
        if (cyc_en) begin
            st_d.pc    = nxt_pc;
            st_d.flush = (src != SRC_INC);
            st_d.ovf   = want_push && stk_full;
            st_d.udf   = want_pop && stk_empty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc      = st_q.pc;
    assign flush   = st_q.flush;
    assign stk_ovf = st_q.ovf;
    assign stk_udf = st_q.udf;
endmodule

// File: rtl/pas_checker.sv
module pas_checker #(
    parameter int PC_W     = 14,
    parameter int LO_W     = 8,
    parameter int IRQ_W    = 3,
    parameter int N_IRQ    = 6,
    parameter int VEC_STEP = 4,
    parameter int BP_W     = 8,
    parameter int BANK_BIT = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_en,
    input logic             irq_valid,
    input logic [IRQ_W-1:0] irq_sel,
    input logic             do_ret,
    input logic             do_jump,
    input logic             do_call,
    input logic             wr_lo,
    input logic [LO_W-1:0]  lo_data,
    input logic             do_skip,
    input logic [PC_W-2:0]  jmp_addr,
    input logic [BP_W-1:0]  bank_ptr,
    input logic [PC_W-1:0]  pc,
    input logic             flush,
    input logic             stk_ovf,
    input logic             stk_udf
);
    logic irq_ok, jmp_only, lowr_only, skip_only, none;
    assign irq_ok    = irq_valid && (32'(irq_sel) < N_IRQ);
    assign jmp_only  = !irq_ok && !do_ret && (do_jump || do_call);
    assign lowr_only = !irq_ok && !do_ret && !do_jump && !do_call && wr_lo;
    assign skip_only = !irq_ok && !do_ret && !do_jump && !do_call && !wr_lo && do_skip;
    assign none      = !irq_ok && !do_ret && !do_jump && !do_call && !wr_lo && !do_skip;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(pc) && $stable(flush) && $stable(stk_ovf) && $stable(stk_udf));

    p_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en && none |=> (pc == $past(pc) + PC_W'(1)) && !flush);

    p_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en && irq_ok |=> (pc[1:0] == 2'b00) && (32'(pc) <= N_IRQ * VEC_STEP) && (pc != '0));

    p_skip_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en && skip_only |=> (pc[PC_W-1] == $past(pc[PC_W-1]))
                               && (pc[PC_W-2:0] == $past(pc[PC_W-2:0]) + (PC_W-1)'(2)));

    p_low_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en && lowr_only |=> (pc[PC_W-1:LO_W] == $past(pc[PC_W-1:LO_W]))
                               && (pc[LO_W-1:0] == $past(lo_data)));

    p_jump_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en && jmp_only |=> pc == {$past(bank_ptr[BANK_BIT]), $past(jmp_addr)});

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en && !none |=> flush);

    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_ovf && stk_udf));
endmodule

bind prog_addr_seq pas_checker #(
    .PC_W(PC_W), .LO_W(LO_W), .IRQ_W(IRQ_W), .N_IRQ(N_IRQ),
    .VEC_STEP(VEC_STEP), .BP_W(BP_W), .BANK_BIT(BANK_BIT)
) u_pas_checker (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .irq_valid(irq_valid),
    .irq_sel(irq_sel), .do_ret(do_ret), .do_jump(do_jump), .do_call(do_call),
    .wr_lo(wr_lo), .lo_data(lo_data), .do_skip(do_skip), .jmp_addr(jmp_addr),
    .bank_ptr(bank_ptr), .pc(pc), .flush(flush), .stk_ovf(stk_ovf), .stk_udf(stk_udf)
);

// File: tb/tb_prog_addr_seq.sv
module tb_prog_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b0;
    logic        irq_valid = 1'b0;
    logic [2:0]  irq_sel = '0;
    logic        do_ret = 1'b0, do_jump = 1'b0, do_call = 1'b0;
    logic        wr_lo = 1'b0, do_skip = 1'b0;
    logic [7:0]  lo_data = '0;
    logic [12:0] jmp_addr = '0;
    logic [7:0]  bank_ptr = '0;
    logic [13:0] pc;
    logic        flush, stk_ovf, stk_udf;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .irq_valid(irq_valid),
        .irq_sel(irq_sel), .do_ret(do_ret), .do_jump(do_jump), .do_call(do_call),
        .wr_lo(wr_lo), .lo_data(lo_data), .do_skip(do_skip), .jmp_addr(jmp_addr),
        .bank_ptr(bank_ptr), .pc(pc), .flush(flush), .stk_ovf(stk_ovf), .stk_udf(stk_udf)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    int    m_pc = 0, m_flush = 0, m_ovf = 0, m_udf = 0, m_last = 0;
    int    m_stk[$];
    string tag = "R1";
    int    n_clk = 0;

    function automatic void m_push(int v);
        m_stk.push_back(v & 'h3FFF);
        if (m_stk.size() > 8) begin
            void'(m_stk.pop_front());
            m_ovf = 1;
        end
    endfunction

    function automatic int m_pop();
        if (m_stk.size() == 0) begin
            m_udf = 1;
            return m_last;
        end
        m_last = m_stk.pop_back();
        return m_last;
    endfunction

    // reference model: next state for the inputs applied now
    task automatic model_step();
        int act;
        if (!rst_n) begin
            m_pc = 0; m_flush = 0; m_ovf = 0; m_udf = 0; m_last = 0;
            m_stk.delete();
            tag = "R1";
        end else if (!cyc_en) begin
            tag = "R2";
        end else begin
            act = int'(irq_valid && irq_sel < 6) + int'(do_ret) + int'(do_jump || do_call)
                + int'(wr_lo) + int'(do_skip);
            m_ovf = 0; m_udf = 0; m_flush = 1;
            if (irq_valid && irq_sel < 6) begin
                m_push(m_pc + 1); m_pc = (int'(irq_sel) + 1) * 4; tag = "R4";
            end else if (do_ret) begin
                m_pc = m_pop(); tag = "R8";
            end else if (do_jump || do_call) begin
                if (do_call) m_push(m_pc + 1);
                m_pc = (int'(bank_ptr[5]) << 13) | int'(jmp_addr); tag = "R7";
            end else if (wr_lo) begin
                m_pc = (m_pc & 'h3F00) | int'(lo_data); tag = "R6";
            end else if (do_skip) begin
                m_pc = (m_pc & 'h2000) | ((m_pc + 2) & 'h1FFF); tag = "R5";
            end else begin
                m_pc = (m_pc + 1) & 'h3FFF; m_flush = 0; tag = "R3";
            end
            if (act > 1) tag = "R9";
            if (m_ovf != 0) tag = "R11";
            if (m_udf != 0) tag = "R12";
        end
    endtask

    task automatic check_one(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        check_one(tag, int'(pc), m_pc, "pc");
        check_one((tag == "R1" || tag == "R2") ? tag : "R10", int'(flush), m_flush, "flush");
        check_one((tag == "R1" || tag == "R2") ? tag : "R11", int'(stk_ovf), m_ovf, "stk_ovf");
        check_one((tag == "R1" || tag == "R2") ? tag : "R12", int'(stk_udf), m_udf, "stk_udf");
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic clear_ctl();
        irq_valid = 0; irq_sel = '0; do_ret = 0; do_jump = 0; do_call = 0;
        wr_lo = 0; do_skip = 0; lo_data = '0; jmp_addr = '0; bank_ptr = '0;
    endtask

    // one instruction cycle: strobe clock then three idle clocks with junk inputs (R2)
    task automatic instr();
        cyc_en = 1; tick();
        cyc_en = 0;
        for (int k = 0; k < 3; k++) begin
            irq_valid = 1'($urandom); irq_sel = 3'($urandom); do_ret = 1'($urandom);
            do_jump = 1'($urandom); do_call = 1'($urandom); wr_lo = 1'($urandom);
            do_skip = 1'($urandom); lo_data = 8'($urandom); jmp_addr = 13'($urandom);
            bank_ptr = 8'($urandom);
            tick();
        end
        clear_ctl();
    endtask

    task automatic go_to(int addr);
        clear_ctl(); do_jump = 1; jmp_addr = 13'(addr); bank_ptr[5] = 1'(addr >> 13); instr();
    endtask

    always @(posedge clk) begin
        n_clk++;
        if (n_clk > WATCHDOG) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", n_clk, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        clear_ctl(); rst_n = 0;
        tick(); tick();                          // R1 reset state
        rst_n = 1;
        for (int i = 0; i < 3; i++) instr();     // R3 increments
        for (int s = 0; s < 8; s++) begin        // R4 every vector, 6 and 7 ignored
            clear_ctl(); irq_valid = 1; irq_sel = 3'(s); do_skip = (s >= 6); instr();
        end
        go_to('h3FFF); clear_ctl(); do_skip = 1; instr();   // R5 wrap keeps bank 1
        go_to('h1FFE); clear_ctl(); do_skip = 1; instr();   // R5 wrap keeps bank 0
        go_to('h2A55); clear_ctl(); wr_lo = 1; lo_data = 8'hC3; instr(); // R6
        clear_ctl(); do_call = 1; jmp_addr = 13'h0123; bank_ptr = 8'h20; instr(); // R7
        instr();
        clear_ctl(); do_ret = 1; instr();                   // R8
        for (int i = 0; i < 9; i++) begin                   // R11 nine nested calls
            clear_ctl(); do_call = 1; jmp_addr = 13'(i * 16 + 5); instr();
        end
        for (int i = 0; i < 10; i++) begin clear_ctl(); do_ret = 1; instr(); end // R12
        clear_ctl(); irq_valid = 1; irq_sel = 3'd2; do_ret = 1; do_jump = 1;
        wr_lo = 1; do_skip = 1; instr();                    // R9 all at once
        clear_ctl(); do_ret = 1; do_call = 1; jmp_addr = 13'h1111; instr();
        clear_ctl(); do_jump = 1; wr_lo = 1; jmp_addr = 13'h0777; instr();
        clear_ctl(); wr_lo = 1; do_skip = 1; lo_data = 8'h10; instr();
        clear_ctl(); rst_n = 0; tick(); rst_n = 1;          // R1 mid-run reset
        clear_ctl(); do_ret = 1; instr();                   // R12 after reset gives 0
        for (int i = 0; i < 1500; i++) begin
            clear_ctl();
            irq_valid = ($urandom % 8) == 0; irq_sel = 3'($urandom);
            do_ret = ($urandom % 6) == 0; do_jump = ($urandom % 8) == 0;
            do_call = ($urandom % 6) == 0; wr_lo = ($urandom % 8) == 0;
            do_skip = ($urandom % 5) == 0; lo_data = 8'($urandom);
            jmp_addr = 13'($urandom); bank_ptr = 8'($urandom);
            instr();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule